// File: doc/BRIEF.md
# Fractional-Rate Nanosecond Time Counter

This block keeps a free-running time of day for precision time stamping. It holds a 64-bit count of whole nanoseconds and a 32-bit fraction of a nanosecond. On every core clock cycle in which it is enabled, it adds a programmable per-cycle step to that pair. The step is a 32.32 fixed-point number of nanoseconds.

Software picks the nominal step as (10^9 << 32) divided by the core clock frequency. For example, an 800 MHz core clock gives a step of 1.25 ns, which is 0x1_4000_0000. Software then trims the frequency by rewriting the step while the counter runs. Because the fraction keeps its remainder from cycle to cycle, the counter can follow any non-integer clock period without drift.

Access is through a plain 64-bit register port. Writes take effect on a single-cycle strobe. Read data is registered and appears one cycle after the read strobe. The current nanosecond count is also driven on a dedicated output for time-stamping logic next to the block.

Top module: `frac_time_counter`

## Requirements
- R1: After reset the control register, the step register, the fraction and the nanosecond count all read as zero.
- R2: Bit 0 of the control register (offset 0xF00) is the enable. While it is 1, the count advances on every clock. While it is 0, both the count and the fraction hold. The other control bits read back as zero.
- R3: Each enabled cycle adds the step's low 32 bits to the fraction. It adds the step's high 32 bits to the nanosecond count. When the fraction addition overflows 32 bits, one extra nanosecond is added in that same cycle.
- R4: A write to the step register (offset 0xF18) is used from the next clock on, including while the counter runs. The count keeps its value across the change.
- R5: A read of offset 0xF10 returns the 64-bit nanosecond count. A read of offset 0xF08 returns the fraction in bits [31:0], with bits [63:32] zero.
- R6: A write to 0xF10 loads the nanosecond count, and a write to 0xF08 loads the fraction from wrData[31:0]. A load wins over the advance of that field in the same cycle, while the other field still advances. When the count is loaded, a fraction carry from that cycle is dropped.
- R7: Reads of any other offset return zero, and writes to any other offset change nothing.
- R8: Read data appears on the clock after the read strobe. It shows the register value as it was before that clock edge, and it holds until the next read strobe.
- R9: Clearing the enable and setting it again resumes counting from the held value.
- R10: The nanosecond count wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W (12) | Register byte offset |
| wrEn | input | 1 | Single-cycle write strobe |
| wrData | input | 64 | Write data |
| rdEn | input | 1 | Single-cycle read strobe |
| rdData | output | 64 | Registered read data |
| timeNs | output | 64 | Current nanosecond count |

## Verification
The hardest situation to reach from the ports is a register load or a step change landing in the same cycle as a fraction carry while the counter runs. Only steps whose fraction overflows within a few cycles make that collision likely. The stimulus uses steps with large fractional parts, such as 0x1_C000_0000 and 0x0_FFFF_FFFF, and issues loads and step rewrites on consecutive cycles while counting is enabled. A reference model in the bench tracks every cycle, so each collision is checked wherever it falls. A single gated advance of the 1.25 ns step is also repeated four times, and the exact carry result of 5 ns with zero fraction is checked against fixed constants.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int TIME_W = 64;
  localparam int FRAC_W = 32;
  localparam int STEP_INT_W = TIME_W - FRAC_W;
  localparam int NUM_REGS = 4;

  typedef struct packed {
    logic              run;
    logic              loadNs;
    logic              loadFrac;
    logic [TIME_W-1:0] loadVal;
  } ctlStrobes_t;
endpackage

// File: rtl/ftc_accum.sv
module ftc_accum
  import ftc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [TIME_W-1:0] stepVal,
  output logic [TIME_W-1:0] nsVal,
  output logic [FRAC_W-1:0] fracVal
);
  logic [TIME_W-1:0] nsReg;
  logic [FRAC_W-1:0] fracReg;
  logic [FRAC_W:0]   fracSum;
  logic [TIME_W-1:0] nsSum;
  logic [TIME_W-1:0] nsNext;
  logic [FRAC_W-1:0] fracNext;

  always_comb begin
    fracSum = {1'b0, fracReg} + {1'b0, stepVal[FRAC_W-1:0]};
    nsSum   = nsReg + {{FRAC_W{1'b0}}, stepVal[TIME_W-1:FRAC_W]}
                    + {{(TIME_W-1){1'b0}}, fracSum[FRAC_W]};
  end

  always_comb begin
    nsNext   = nsReg;
    fracNext = fracReg;
    if (strb.run) begin
      nsNext   = nsSum;
      fracNext = fracSum[FRAC_W-1:0];
    end
    if (strb.loadNs)   nsNext   = strb.loadVal;
    if (strb.loadFrac) fracNext = strb.loadVal[FRAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nsReg   <= '0;
      fracReg <= '0;
    end else begin
      nsReg   <= nsNext;
      fracReg <= fracNext;
    end
  end

  assign nsVal   = nsReg;
  assign fracVal = fracReg;

  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.loadNs && !strb.loadFrac) |=> ($stable(nsReg) && $stable(fracReg)));

  assert_step_or_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.loadNs && !strb.loadFrac) |=>
      (((nsReg - $past(nsReg)) == {{FRAC_W{1'b0}}, $past(stepVal[TIME_W-1:FRAC_W])}) ||
       ((nsReg - $past(nsReg)) == ({{FRAC_W{1'b0}}, $past(stepVal[TIME_W-1:FRAC_W])} + 64'd1))));

  assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadNs |=> (nsReg == $past(strb.loadVal)));
endmodule

// File: rtl/ftc_regctl.sv
module ftc_regctl
  import ftc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFFS = 12'hF00,
  parameter logic [ADDR_W-1:0] FRAC_OFFS = 12'hF08,
  parameter logic [ADDR_W-1:0] NS_OFFS   = 12'hF10,
  parameter logic [ADDR_W-1:0] STEP_OFFS = 12'hF18
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [TIME_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [TIME_W-1:0] nsVal,
  input  logic [FRAC_W-1:0] fracVal,
  output ctlStrobes_t       strb,
  output logic [TIME_W-1:0] stepVal,
  output logic [TIME_W-1:0] rdData
);
  localparam int IDX_CTRL = 0;
  localparam int IDX_FRAC = 1;
  localparam int IDX_NS   = 2;
  localparam int IDX_STEP = 3;
  localparam logic [NUM_REGS-1:0][ADDR_W-1:0] OFFS_TABLE =
    {STEP_OFFS, NS_OFFS, FRAC_OFFS, CTRL_OFFS};

  logic [NUM_REGS-1:0] hit;
  logic                enableBit;
  logic [TIME_W-1:0]   stepReg;
  logic [TIME_W-1:0]   rdMux;
  logic [TIME_W-1:0]   rdReg;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_decode
    assign hit[g] = (regAddr == OFFS_TABLE[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableBit <= 1'b0;
      stepReg   <= '0;
    end else if (wrEn) begin
      if (hit[IDX_CTRL]) enableBit <= wrData[0];
      if (hit[IDX_STEP]) stepReg   <= wrData;
    end
  end

  always_comb begin
    strb.run      = enableBit;
    strb.loadNs   = wrEn && hit[IDX_NS];
    strb.loadFrac = wrEn && hit[IDX_FRAC];
    strb.loadVal  = wrData;
  end

  always_comb begin
    rdMux = '0;
    unique case (1'b1)
      hit[IDX_CTRL]: rdMux = {{(TIME_W-1){1'b0}}, enableBit};
      hit[IDX_FRAC]: rdMux = {{(TIME_W-FRAC_W){1'b0}}, fracVal};
      hit[IDX_NS]:   rdMux = nsVal;
      hit[IDX_STEP]: rdMux = stepReg;
      default:       rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdReg <= '0;
    else if (rdEn) rdReg <= rdMux;
  end

  assign stepVal = stepReg;
  assign rdData  = rdReg;

  assert_unmapped_write_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (hit == '0)) |=> ($stable(enableBit) && $stable(stepReg)));

  assert_read_data_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  assert_decode_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hit));
endmodule

// File: rtl/frac_time_counter.sv
module frac_time_counter
  import ftc_pkg::*;
#(
  parameter int ADDR_W = 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [63:0]       wrData,
  input  logic              rdEn,
  output logic [63:0]       rdData,
  output logic [63:0]       timeNs
);
  ctlStrobes_t       strb;
  logic [TIME_W-1:0] stepVal;
  logic [TIME_W-1:0] nsVal;
  logic [FRAC_W-1:0] fracVal;

  ftc_regctl #(
    .ADDR_W(ADDR_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .nsVal(nsVal), .fracVal(fracVal), .strb(strb),
    .stepVal(stepVal), .rdData(rdData)
  );

  ftc_accum acc_i (
    .clk(clk), .rstN(rstN), .strb(strb), .stepVal(stepVal),
    .nsVal(nsVal), .fracVal(fracVal)
  );

  assign timeNs = nsVal;
endmodule

// File: tb/frac_time_counter_tb_top.sv
module frac_time_counter_tb_top;
  localparam logic [11:0] A_CTRL = 12'hF00;
  localparam logic [11:0] A_FRAC = 12'hF08;
  localparam logic [11:0] A_NS   = 12'hF10;
  localparam logic [11:0] A_STEP = 12'hF18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [63:0] rdData;
  logic [63:0] timeNs;

  int applied = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 0;

  logic [63:0] expQ[$];
  string       tagQ[$];
  logic        readPend = 1'b0;

  logic        mEn;
  logic [63:0] mStep;
  logic [63:0] mNs;
  logic [31:0] mFrac;
  logic [32:0] fs;
  logic [63:0] nNs;
  logic [31:0] nFrac;

  always #5 clk = ~clk;

  frac_time_counter dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .timeNs(timeNs)
  );

  // Reference model stepped from the requirements
  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 1'b0; mStep = '0; mNs = '0; mFrac = '0;
    end else begin
      fs = {1'b0, mFrac} + {1'b0, mStep[31:0]};
      nNs = mNs; nFrac = mFrac;
      if (mEn) begin
        nNs = mNs + {32'd0, mStep[63:32]} + {63'd0, fs[32]};
        nFrac = fs[31:0];
      end
      if (wrEn) begin
        case (regAddr)
          A_CTRL: mEn = wrData[0];
          A_FRAC: nFrac = wrData[31:0];
          A_NS:   nNs = wrData;
          A_STEP: mStep = wrData;
          default: ;
        endcase
      end
      mNs = nNs; mFrac = nFrac;
    end
    readPend <= rdEn;
    cycles++;
  end

  function automatic logic [63:0] modelRead(logic [11:0] a);
    case (a)
      A_CTRL:  return {63'd0, mEn};
      A_FRAC:  return {32'd0, mFrac};
      A_NS:    return mNs;
      A_STEP:  return mStep;
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops scoreboard entries as read data appears
  always @(negedge clk) begin
    if (readPend && rstN) begin
      if (expQ.size() == 0) check("R8 unexpected read data", rdData, 64'hx);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic wrReg(logic [11:0] a, logic [63:0] d);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(logic [11:0] a, string tag);
    rdEn = 1'b1; regAddr = a;
    expQ.push_back(modelRead(a)); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdConst(logic [11:0] a, logic [63:0] e, string tag);
    rdEn = 1'b1; regAddr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 150000) begin
      miscompares++;
      applied++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  logic [63:0] held;

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdReg(A_CTRL, "R1 ctrl"); rdReg(A_FRAC, "R1 frac");
    rdReg(A_NS, "R1 ns");     rdReg(A_STEP, "R1 step");
    idle(2);

    // R3 exact carry: four single gated advances of 1.25 ns
    wrReg(A_STEP, 64'h1_4000_0000);
    for (int k = 0; k < 4; k++) begin
      wrReg(A_CTRL, 64'd1);
      wrReg(A_CTRL, 64'd0);
    end
    rdConst(A_NS, 64'd5, "R3 carry ns");
    rdConst(A_FRAC, 64'd0, "R3 carry frac");
    rdConst(A_CTRL, 64'd0, "R2 ctrl off");

    // R2 and R9: hold while disabled, resume from held value
    wrReg(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFF);
    rdReg(A_CTRL, "R2 ctrl upper bits zero");
    idle(7);
    rdReg(A_NS, "R2 running ns");
    wrReg(A_CTRL, 64'd0);
    idle(5);
    rdReg(A_NS, "R2 held ns"); rdReg(A_FRAC, "R2 held frac");
    wrReg(A_CTRL, 64'd1);
    idle(3);
    rdReg(A_NS, "R9 resume ns"); rdReg(A_FRAC, "R9 resume frac");

    // R4 step changes while running, large fractions
    wrReg(A_STEP, 64'h1_C000_0000);
    rdReg(A_NS, "R4 after step write");
    wrReg(A_STEP, 64'h0_FFFF_FFFF);
    wrReg(A_STEP, 64'h3_8000_0001);
    rdReg(A_NS, "R4 ns"); rdReg(A_FRAC, "R4 frac"); rdReg(A_STEP, "R4 step readback");

    // R6 loads colliding with running advance
    wrReg(A_NS, 64'h0000_1234_5678_9ABC);
    rdReg(A_NS, "R6 ns load"); rdReg(A_FRAC, "R6 frac advanced");
    wrReg(A_FRAC, 64'hDEAD_BEEF_FFFF_FFF0);
    rdReg(A_FRAC, "R6 frac load upper ignored"); rdReg(A_NS, "R6 ns after frac load");
    wrReg(A_NS, 64'd100); wrReg(A_FRAC, 64'hFFFF_FFFF); wrReg(A_NS, 64'd200);
    rdReg(A_NS, "R6 back to back"); rdReg(A_FRAC, "R6 back to back frac");
    check("R5 timeNs port", timeNs, mNs);

    // R7 unmapped offsets
    wrReg(12'hF20, 64'hFFFF);
    wrReg(12'h700, 64'd0);
    wrReg(12'hF19, 64'h5);
    rdReg(12'hF20, "R7 unmapped read"); rdReg(12'h000, "R7 unmapped read low");
    rdReg(A_CTRL, "R7 ctrl unchanged"); rdReg(A_STEP, "R7 step unchanged");

    // R10 wrap
    wrReg(A_STEP, 64'h10_8000_0000);
    wrReg(A_NS, 64'hFFFF_FFFF_FFFF_FFC0);
    idle(6);
    rdReg(A_NS, "R10 wrapped ns"); rdReg(A_FRAC, "R10 frac");

    // R8 hold of read data between strobes
    rdReg(A_NS, "R8 read");
    @(negedge clk);
    held = rdData;
    idle(4);
    check("R8 rdData holds", rdData, held);

    // Mixed pattern with pseudo-random steps and loads
    for (int n = 0; n < 40; n++) begin
      wrReg(A_STEP, {32'($urandom_range(0, 9)), 32'($urandom)});
      if (n % 5 == 0) wrReg(A_FRAC, {32'd0, 32'($urandom)});
      if (n % 7 == 0) wrReg(A_CTRL, 64'(n % 2));
      idle(n % 4);
      rdReg(A_NS, "R3 mixed ns"); rdReg(A_FRAC, "R3 mixed frac");
    end
    wrReg(A_CTRL, 64'd1);
    idle(20);
    rdReg(A_NS, "R3 final ns");
    idle(3);
    finishRun();
  end
endmodule